// File: doc/BRIEF.md
# Burst Fragmenter with Bus-Yield Limit

This block serves one direction of a memory copy or fill engine, either the reads of the source or the writes of the destination. It takes a start address and a byte length and turns them into a series of bus burst commands. Each command carries an address and a byte count. The byte count never exceeds a configured maximum burst size. When two directions are needed, the engine uses two instances, each with its own burst size and back-to-back limit.

The block also stops itself from holding the bus for too long. After it has issued a configured number of bursts in a row, it drops its command request for a programmable number of idle cycles, so that other bus masters get a turn. It then continues with the next burst.

Commands leave the block on a valid/ready stream. When `cmd_valid` is high and `cmd_ready` is low, the block holds the command still: `cmd_valid` stays high and `cmd_addr` and `cmd_bytes` do not change. A command is accepted on a clock edge where both signals are high. `cmd_valid` does not depend on `cmd_ready`. The `start`, `busy` and `done` pins and the configuration inputs are plain control signals. The configuration inputs are captured when a transfer is accepted.

Top module: `burst_fragmenter`

## Requirements
- R1: Each burst's `cmd_bytes` is the smaller of the remaining byte count and the captured maximum burst size. A maximum burst size of 0 is treated as 1.
- R2: The first burst uses the start address. Each later burst's address is the previous burst's address plus the previous burst's byte count.
- R3: After a number of consecutive accepted bursts equal to the captured run limit (0 treated as 1), if bytes remain, `cmd_valid` stays low for exactly the captured yield count of cycles (0 treated as 1). It then rises again and a new run begins. The run count starts at zero at the beginning of each transfer.
- R4: `done` is high for exactly one cycle: the cycle after the edge that accepts the final burst. No yield gap comes before it, and `cmd_valid` is low while it is high.
- R5: A request with length 0 issues no burst and raises `done` in the cycle after `start` is accepted.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_addr` and `cmd_bytes` hold their values. `cmd_valid` never depends on `cmd_ready`.
- R7: `busy` is high from the cycle after an accepted `start` up to and including the `done` cycle. A `start` pulse while `busy` is high is ignored.
- R8: Start address, length, maximum burst size, run limit and yield count are captured when a transfer is accepted. Changes on those inputs during a transfer have no effect on it.
- R9: After reset, `cmd_valid`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer (accepted when not busy) |
| start_addr | input | ADDR_W | First byte address |
| start_len | input | LEN_W | Total byte count |
| cfg_max_burst | input | BURST_W | Largest burst in bytes (0 means 1) |
| cfg_max_run | input | RUN_W | Bursts allowed back to back (0 means 1) |
| cfg_yield_cycles | input | GAP_W | Idle cycles per yield (0 means 1) |
| cmd_valid | output | 1 | Burst command present |
| cmd_ready | input | 1 | Bus accepts the command |
| cmd_addr | output | ADDR_W | Burst start address |
| cmd_bytes | output | BURST_W | Burst byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench aims at the following corner cases:

- Lengths that are an exact multiple of the burst size, lengths with a short remainder, and lengths smaller than a single burst. A design with a wrong minimum would send an oversized final burst or a zero-byte burst.
- A final burst that coincides with the end of a run. A design that got this wrong would insert a needless yield gap before `done`.
- A run limit of one, and zero-valued configuration fields. A design that mishandled these would never yield, yield one cycle short, or stall.
- Random back-pressure together with `start` pulses and configuration changes during a transfer. A design that got this wrong would change the held command, skip or repeat bytes, or restart mid-transfer.

// File: rtl/bfrag_pkg.sv
package bfrag_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_XFER = 2'd1,
    FR_DONE = 2'd2
  } fr_state_e;
endpackage

// File: rtl/bfrag_size.sv
module bfrag_size #(
  parameter int LEN_W   = 20,
  parameter int BURST_W = 12
) (
  input  logic [LEN_W-1:0]   remain,
  input  logic [BURST_W-1:0] max_bytes,
  output logic [BURST_W-1:0] bytes,
  output logic               is_last
);
  localparam int PAD_W = LEN_W - BURST_W;

  logic [LEN_W-1:0] max_ext;

  assign max_ext = {{PAD_W{1'b0}}, max_bytes};

  always_comb begin
    if (remain <= max_ext) begin
      bytes   = remain[BURST_W-1:0];
      is_last = 1'b1;
    end else begin
      bytes   = max_bytes;
      is_last = 1'b0;
    end
  end
endmodule

// File: rtl/bfrag_pacer.sv
module bfrag_pacer #(
  parameter int RUN_W = 6,
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             fire,
  input  logic             last,
  input  logic [RUN_W-1:0] run_lim,
  input  logic [GAP_W-1:0] gap_len,
  output logic             yield_now,
  output logic             gap_busy
);
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);
  localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

  logic [RUN_W-1:0] run_cnt;
  logic [GAP_W-1:0] gap_cnt;

  assign yield_now = fire && !last && (run_cnt == run_lim - RUN_ONE);
  assign gap_busy  = (gap_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      gap_cnt <= '0;
    end else if (clear) begin
      run_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      if (yield_now)
        run_cnt <= '0;
      else if (fire)
        run_cnt <= run_cnt + RUN_ONE;

      if (yield_now)
        gap_cnt <= gap_len;
      else if (gap_busy)
        gap_cnt <= gap_cnt - GAP_ONE;
    end
  end

  // R3
  run_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear) |-> (run_cnt < run_lim));

  // R3
  gap_follows_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (yield_now && !clear) |=> (gap_busy && !fire));
endmodule

// File: rtl/burst_fragmenter.sv
module burst_fragmenter #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 20,
  parameter int BURST_W = 12,
  parameter int RUN_W   = 6,
  parameter int GAP_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [LEN_W-1:0]   start_len,
  input  logic [BURST_W-1:0] cfg_max_burst,
  input  logic [RUN_W-1:0]   cfg_max_run,
  input  logic [GAP_W-1:0]   cfg_yield_cycles,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [BURST_W-1:0] cmd_bytes,
  output logic               busy,
  output logic               done
);
  import bfrag_pkg::*;

  localparam logic [BURST_W-1:0] BURST_ONE = BURST_W'(1);
  localparam logic [RUN_W-1:0]   RUN_ONE   = RUN_W'(1);
  localparam logic [GAP_W-1:0]   GAP_ONE   = GAP_W'(1);

  fr_state_e          st;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   rem_q;
  logic [BURST_W-1:0] mb_q;
  logic [RUN_W-1:0]   mr_q;
  logic [GAP_W-1:0]   gap_q;

  logic [BURST_W-1:0] next_bytes;
  logic               next_last;
  logic               fire;
  logic               yield_now;
  logic               gap_busy;
  logic               accept;

  bfrag_size #(.LEN_W(LEN_W), .BURST_W(BURST_W)) u_size (
    .remain   (rem_q),
    .max_bytes(mb_q),
    .bytes    (next_bytes),
    .is_last  (next_last)
  );

  bfrag_pacer #(.RUN_W(RUN_W), .GAP_W(GAP_W)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (st != FR_XFER),
    .fire     (fire),
    .last     (next_last),
    .run_lim  (mr_q),
    .gap_len  (gap_q),
    .yield_now(yield_now),
    .gap_busy (gap_busy)
  );

  assign cmd_valid = (st == FR_XFER) && !gap_busy;
  assign cmd_addr  = addr_q;
  assign cmd_bytes = next_bytes;
  assign fire      = cmd_valid && cmd_ready;
  assign busy      = (st != FR_IDLE);
  assign done      = (st == FR_DONE);
  assign accept    = (st == FR_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FR_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      mb_q   <= BURST_ONE;
      mr_q   <= RUN_ONE;
      gap_q  <= GAP_ONE;
    end else begin
      case (st)
        FR_IDLE: if (accept) begin
          addr_q <= start_addr;
          rem_q  <= start_len;
          mb_q   <= (cfg_max_burst == '0)    ? BURST_ONE : cfg_max_burst;
          mr_q   <= (cfg_max_run == '0)      ? RUN_ONE   : cfg_max_run;
          gap_q  <= (cfg_yield_cycles == '0) ? GAP_ONE   : cfg_yield_cycles;
          st     <= (start_len == '0) ? FR_DONE : FR_XFER;
        end
        FR_XFER: if (fire) begin
          addr_q <= addr_q + ADDR_W'(next_bytes);
          rem_q  <= rem_q - LEN_W'(next_bytes);
          if (next_last) st <= FR_DONE;
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  // R1
  burst_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_bytes != '0) && (cmd_bytes <= mb_q));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cmd_addr == $past(cmd_addr) + ADDR_W'($past(cmd_bytes))));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_len == '0) |=> (done && !cmd_valid));

  // R6
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_bytes)));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/tb_burst_fragmenter.sv
module tb_burst_fragmenter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [19:0] start_len = '0;
  logic [11:0] cfg_max_burst = '0;
  logic [5:0]  cfg_max_run = '0;
  logic [5:0]  cfg_yield_cycles = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_addr;
  logic [11:0] cmd_bytes;
  logic        busy;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  burst_fragmenter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .cfg_max_burst(cfg_max_burst), .cfg_max_run(cfg_max_run),
    .cfg_yield_cycles(cfg_yield_cycles), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int min_burst(input int rem, input int mb);
    return (rem < mb) ? rem : mb;
  endfunction

  task automatic xfer(input longint a0, input int len, input int mb, input int mr,
                      input int yc, input int rdy_pct);
    longint a;
    int rem, mbe, mre, yce, run, gap, b, guard;
    bit fire, exp_v;
    @(negedge clk);
    start = 1'b1; start_addr = 32'(a0); start_len = 20'(len);
    cfg_max_burst = 12'(mb); cfg_max_run = 6'(mr); cfg_yield_cycles = 6'(yc);
    @(negedge clk);
    start = 1'b0;
    mbe = eff(mb); mre = eff(mr); yce = eff(yc);
    a = a0; rem = len; run = 0; gap = 0; b = 0; guard = 0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    if (len != 0) begin
      forever begin
        // R7 R8: start pulses and config changes mid-transfer must be ignored
        cmd_ready = (($urandom % 100) < 32'(rdy_pct));
        start = (($urandom % 6) == 0);
        start_len = '0;
        start_addr = $urandom;
        cfg_max_burst = 12'($urandom);
        cfg_max_run = 6'($urandom);
        cfg_yield_cycles = 6'($urandom);
        exp_v = (gap == 0);
        chk(cmd_valid == exp_v, "R3 valid vs yield gap", cmd_valid, exp_v);
        chk(done == 1'b0, "R4 no early done", done, 0);
        if (exp_v) begin
          b = min_burst(rem, mbe);
          chk(cmd_addr == 32'(a), "R2 burst address", cmd_addr, a & 64'hFFFFFFFF);
          chk(cmd_bytes == 12'(b), "R1 burst bytes", cmd_bytes, b);
        end
        fire = exp_v && cmd_ready;
        @(negedge clk);
        guard++;
        if (fire) begin
          a += b; rem -= b; run++;
          if (rem == 0) break;
          if (run == mre) begin gap = yce; run = 0; end
        end else if (gap > 0) begin
          gap--;
        end
        if (guard > 60000) break;
      end
      start = 1'b0;
      chk(done == 1'b1, "R4 done after final burst", done, 1);
      chk(cmd_valid == 1'b0, "R4 valid low with done", cmd_valid, 0);
    end else begin
      chk(done == 1'b1, "R5 zero length done", done, 1);
      chk(cmd_valid == 1'b0, "R5 zero length no burst", cmd_valid, 0);
    end
    chk(busy == 1'b1, "R7 busy during done", busy, 1);
    cmd_ready = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R4 done single cycle", done, 0);
    chk(busy == 1'b0, "R7 idle after done", busy, 0);
    chk(cmd_valid == 1'b0, "R5 no burst after done", cmd_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9
    chk(cmd_valid == 1'b0, "R9 reset valid", cmd_valid, 0);
    chk(done == 1'b0, "R9 reset done", done, 0);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 idle after reset", busy, 0);

    xfer(64'h1000, 4096, 1024, 31, 3, 100);  // R1 exact multiple
    xfer(64'h2000, 40000, 1024, 31, 4, 70);  // R3 typical setting, one yield
    xfer(64'h3000, 1000, 100, 1, 2, 60);     // R3 yield after every burst
    xfer(64'h4000, 300, 100, 3, 5, 100);     // R4 last burst closes a run
    xfer(64'h5000, 37, 512, 2, 1, 50);       // R1 shorter than one burst
    xfer(64'h6000, 0, 64, 2, 2, 100);        // R5 zero length
    xfer(64'h7000, 7, 0, 0, 0, 100);         // R1 R3 zero config fields
    xfer(64'h8000, 1030, 256, 2, 0, 30);     // R6 heavy back-pressure
    for (int i = 0; i < 24; i++) begin
      xfer(longint'($urandom % 32'h10000000), int'($urandom % 4000),
           int'(16 + $urandom % 497), int'($urandom % 7), int'($urandom % 6),
           int'(20 + $urandom % 81));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule